// File: doc/BRIEF.md
# Seconds Divider with Digital Rate Trim

This block turns a stream of oscillator strobes, nominally 32,768 per second, into a one-cycle seconds pulse. The oscillator's rate error is corrected digitally: across a repeating 64-minute trim cycle, the first second of some minutes is shortened or lengthened by a fixed number of oscillator counts. A 6-bit trim word sets both the direction and the number of minutes adjusted. A test mode produces a 512 Hz square wave straight from the undivided strobes, so that the raw oscillator rate can be measured. An oscillator-stop input freezes all counting.

The oscillator strobe `osc_tick` is a single-cycle pulse in the `clk` domain. The trim word is taken once at reset and again at each trim-cycle boundary. Changing it during a cycle therefore affects only the next cycle.

Top module: `rtc_trim_adjust`

## Requirements
- R1: With no adjustment due, a second lasts TICKS_PER_SEC accepted strobes (default 32,768). `sec_tick` is high for exactly one clock, in the cycle after the clock edge that samples the strobe completing the second.
- R2: With `cal_trim[5]`=1 (fast) and magnitude N=`cal_trim[4:0]`, the first second of each of minutes 0 to 2N-1 of the trim cycle lasts TICKS_PER_SEC-FAST_STEP strobes (default 256 fewer). A minute has SECS_PER_MIN seconds and the cycle has MINS_PER_CYCLE minutes.
- R3: With `cal_trim[5]`=0 (slow) and magnitude N, the first second of each of minutes 0 to 2N-1 lasts TICKS_PER_SEC+SLOW_STEP strobes (default 128 more).
- R4: The number of adjusted minutes is capped at ADJ_MIN_LIMIT (default 62), even when 2N is larger.
- R5: `cal_trim` is sampled only during reset and when the last second of a trim cycle completes. A change during a cycle leaves that cycle's second lengths unchanged.
- R6: While `osc_stop` is 1, strobes are ignored. The divider and the cycle position hold, no `sec_tick` is produced, and `sq_out` holds. Counting resumes from the held state.
- R7: While `test_mode` is 1, `sq_out` toggles after every SQ_HALF_TICKS accepted strobes (default 32, giving 512 Hz). The first toggle, to 1, comes after SQ_HALF_TICKS strobes. The trim value has no effect on it.
- R8: While `test_mode` is 0, `sq_out` is 0 from the next clock, and the square-wave count restarts from zero.
- R9: During reset, `sec_tick` and `sq_out` are 0, and the divider, second and minute counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle oscillator strobe |
| cal_trim | input | 6 | Bits 4..0: trim magnitude; bit 5: 1 = fast, 0 = slow |
| osc_stop | input | 1 | 1 = oscillator stopped; strobes are ignored |
| test_mode | input | 1 | 1 = drive the square wave on `sq_out` |
| sec_tick | output | 1 | One-cycle seconds pulse |
| sq_out | output | 1 | Test square wave, 0 when test mode is off |

## Verification
On every cycle, the assertions check the following:
- a seconds pulse only ever follows an accepted strobe;
- no seconds pulse appears while the oscillator is stopped, and the square wave holds then;
- the square wave changes only on a strobe;
- the square wave drops to 0 once test mode is off.

The length of each second needs the bench's scenarios, which compare every second against an expected list. These scenarios cover:
- fast and slow trims, including the capped span;
- trim changes made in the middle of a cycle, which must not take effect until the next boundary;
- a stop that falls in the middle of a second and must be resumed without loss.

The scenarios also measure the square-wave half period while a trim is active.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam int MAG_W    = 5;
  localparam int SIGN_BIT = 5;

  typedef struct packed {
    logic             fast;
    logic [MAG_W-1:0] mag;
  } trim_t;

  function automatic trim_t decode_trim(input logic [MAG_W:0] raw);
    trim_t t;
    t.fast = raw[SIGN_BIT];
    t.mag  = raw[MAG_W-1:0];
    return t;
  endfunction

  // adjusted minutes per cycle: twice the magnitude, capped
  function automatic int trim_span(input trim_t t, input int limit);
    int s;
    s = 2 * int'(t.mag);
    return (s > limit) ? limit : s;
  endfunction
endpackage

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [CW-1:0] last,
  output logic          wrap
);
  logic [CW-1:0] cnt_q;

  assign wrap = step && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_trim_cycle.sv
module rtc_trim_cycle
  import rtc_trim_pkg::*;
#(
  parameter int SECS  = 60,
  parameter int MINS  = 64,
  parameter int LIMIT = 62
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  wrap,
  input  trim_t cal_in,
  output logic  adj_now,
  output logic  adj_fast
);
  localparam int SW = (SECS > 1) ? $clog2(SECS) : 1;
  localparam int MW = (MINS > 1) ? $clog2(MINS) : 1;

  logic [SW-1:0] sec_q;
  logic [MW-1:0] min_q;
  trim_t         active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q    <= '0;
      min_q    <= '0;
      active_q <= cal_in;
    end else if (wrap) begin
      if (sec_q == SW'(SECS - 1)) begin
        sec_q <= '0;
        if (min_q == MW'(MINS - 1)) begin
          min_q    <= '0;
          active_q <= cal_in;
        end else begin
          min_q <= min_q + 1'b1;
        end
      end else begin
        sec_q <= sec_q + 1'b1;
      end
    end
  end

  always_comb begin
    adj_now  = (sec_q == '0) && (int'(min_q) < trim_span(active_q, LIMIT));
    adj_fast = active_q.fast;
  end
endmodule

// File: rtl/rtc_trim_square.sv
module rtc_trim_square #(
  parameter int HALF = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic en,
  output logic sq
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      sq    <= 1'b0;
    end else if (step) begin
      if (cnt_q == HW'(HALF - 1)) begin
        cnt_q <= '0;
        sq    <= ~sq;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_trim_adjust.sv
module rtc_trim_adjust
  import rtc_trim_pkg::*;
#(
  parameter int TICKS_PER_SEC  = 32768,
  parameter int SECS_PER_MIN   = 60,
  parameter int MINS_PER_CYCLE = 64,
  parameter int ADJ_MIN_LIMIT  = 62,
  parameter int FAST_STEP      = 256,
  parameter int SLOW_STEP      = 128,
  parameter int SQ_HALF_TICKS  = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_tick,
  input  logic [5:0] cal_trim,
  input  logic       osc_stop,
  input  logic       test_mode,
  output logic       sec_tick,
  output logic       sq_out
);
  localparam int CW = $clog2(TICKS_PER_SEC + SLOW_STEP + 1);
  localparam logic [CW-1:0] LAST_NOM  = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] LAST_FAST = CW'(TICKS_PER_SEC - FAST_STEP - 1);
  localparam logic [CW-1:0] LAST_SLOW = CW'(TICKS_PER_SEC + SLOW_STEP - 1);

  logic          step;
  logic          wrap;
  logic          adj_now;
  logic          adj_fast;
  logic [CW-1:0] last_cnt;
  trim_t         cal_in;

  assign step   = osc_tick && !osc_stop;
  assign cal_in = decode_trim(cal_trim);

  always_comb begin
    if (!adj_now)     last_cnt = LAST_NOM;
    else if (adj_fast) last_cnt = LAST_FAST;
    else               last_cnt = LAST_SLOW;
  end

  rtc_trim_divider #(.CW(CW)) div_i (
    .clk(clk), .rst(rst), .step(step), .last(last_cnt), .wrap(wrap)
  );

  rtc_trim_cycle #(
    .SECS(SECS_PER_MIN), .MINS(MINS_PER_CYCLE), .LIMIT(ADJ_MIN_LIMIT)
  ) cyc_i (
    .clk(clk), .rst(rst), .wrap(wrap), .cal_in(cal_in),
    .adj_now(adj_now), .adj_fast(adj_fast)
  );

  rtc_trim_square #(.HALF(SQ_HALF_TICKS)) sq_i (
    .clk(clk), .rst(rst), .step(step), .en(test_mode), .sq(sq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) sec_tick <= 1'b0;
    else     sec_tick <= wrap;
  end
endmodule

// File: rtl/rtc_trim_checker.sv
module rtc_trim_checker (
  input logic clk,
  input logic rst,
  input logic osc_tick,
  input logic osc_stop,
  input logic test_mode,
  input logic sec_tick,
  input logic sq_out
);
  a_r1_tick_after_strobe: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> $past(osc_tick) && !$past(osc_stop));

  a_r6_no_tick_stopped: assert property (@(posedge clk) disable iff (rst)
    osc_stop |=> !sec_tick);

  a_r6_square_holds: assert property (@(posedge clk) disable iff (rst)
    (osc_stop && test_mode) |=> $stable(sq_out));

  a_r7_square_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(sq_out) && $past(test_mode) |-> $past(osc_tick));

  a_r8_square_low_off: assert property (@(posedge clk) disable iff (rst)
    !test_mode |=> !sq_out);
endmodule

bind rtc_trim_adjust rtc_trim_checker chk_i (
  .clk(clk), .rst(rst), .osc_tick(osc_tick), .osc_stop(osc_stop),
  .test_mode(test_mode), .sec_tick(sec_tick), .sq_out(sq_out)
);

// File: tb/rtc_trim_adjust_tb_top.sv
module rtc_trim_adjust_tb_top;
  localparam int T    = 64;
  localparam int SPM  = 4;
  localparam int MPC  = 8;
  localparam int LIM  = 6;
  localparam int FST  = 8;
  localparam int SLW  = 4;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_tick = 1'b0;
  logic [5:0] cal_trim = 6'b100010;
  logic osc_stop = 1'b0;
  logic test_mode = 1'b0;
  logic sec_tick, sq_out;

  always #5 clk = ~clk;

  rtc_trim_adjust #(
    .TICKS_PER_SEC(T), .SECS_PER_MIN(SPM), .MINS_PER_CYCLE(MPC),
    .ADJ_MIN_LIMIT(LIM), .FAST_STEP(FST), .SLOW_STEP(SLW), .SQ_HALF_TICKS(HALF)
  ) dut_i (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .cal_trim(cal_trim),
    .osc_stop(osc_stop), .test_mode(test_mode), .sec_tick(sec_tick), .sq_out(sq_out)
  );

  typedef struct { int len; string tag; } exp_t;
  exp_t exp_q[$];

  int tests = 0, fails = 0;
  int sec_seen = 0, tick_cnt = 0, sq_cnt = 0, phase = 0, bad_off = 0;
  bit gen_on = 0, off_prev = 0, tm_prev = 0, sq_prev = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver side: expected second lengths for one trim cycle
  task automatic push_cycle(input bit fast, input int n, input string tag_adj, input string tag_plain);
    int span;
    span = (2 * n > LIM) ? LIM : 2 * n;
    for (int m = 0; m < MPC; m++) begin
      for (int s = 0; s < SPM; s++) begin
        exp_t e;
        if (s == 0 && m < span) begin
          e.len = fast ? T - FST : T + SLW;
          e.tag = tag_adj;
        end else begin
          e.len = T;
          e.tag = tag_plain;
        end
        exp_q.push_back(e);
      end
    end
  endtask

  // monitor and strobe generator, all at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (sec_tick) begin
        sec_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", tick_cnt, -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(tick_cnt == e.len, e.tag, tick_cnt, e.len);
        end
        tick_cnt = 0;
        if (!tm_prev && !test_mode) check(sq_out == 1'b0, "R8", sq_out, 0);
      end
      if (off_prev && sec_tick) bad_off++;
      if (!test_mode) sq_cnt = 0;
      else if (tm_prev && sq_out != sq_prev) begin
        check(sq_cnt == HALF, "R7", sq_cnt, HALF);
        sq_cnt = 0;
      end
      off_prev = osc_stop;
      tm_prev  = test_mode;
      sq_prev  = sq_out;
      phase++;
      osc_tick = gen_on && (phase % 4 == 0);
      if (osc_tick && !osc_stop) begin
        tick_cnt++;
        if (test_mode) sq_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sec_tick == 1'b0, "R9", sec_tick, 0);
    check(sq_out == 1'b0, "R9", sq_out, 0);
    push_cycle(1'b1, 2, "R2", "R1");
    push_cycle(1'b0, 1, "R3", "R5");
    push_cycle(1'b0, 5, "R4", "R1");
    push_cycle(1'b0, 0, "R1", "R1");
    push_cycle(1'b0, 0, "R5,R6", "R5,R6");
    @(posedge clk); #1;
    rst = 1'b0; gen_on = 1'b1; test_mode = 1'b1;
    wait (sec_seen >= 10);  @(posedge clk); #1 cal_trim = 6'b000001;
    wait (sec_seen >= 40);  @(posedge clk); #1 cal_trim = 6'b000101;
    wait (sec_seen >= 60);  @(posedge clk); #1 test_mode = 1'b0;
    wait (sec_seen >= 70);  @(posedge clk); #1 cal_trim = 6'b000000;
    wait (sec_seen >= 130); @(posedge clk); #1 cal_trim = 6'b100011;
    wait (sec_seen >= 135);
    repeat (37) @(posedge clk);
    #1 osc_stop = 1'b1;
    repeat (2000) @(posedge clk);
    #1 osc_stop = 1'b0;
    wait (sec_seen >= 150);
    @(negedge clk);
    check(bad_off == 0, "R6", bad_off, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule